// File: doc/BRIEF.md
# Passive LCD Timing Generator

This block derives the three timing strobes of a passive-matrix LCD from the system clock: a pixel shift clock, a line pulse that closes every line period, and a frame pulse that marks the first line of every frame. It also exposes a line index, a pixel-beat index and an active-line flag, so that a separate data fetcher can place four-pixel beats on the panel bus in step with the shift clock.

Four settings shape the timing. A speed select picks the shift-clock period. An 8-bit line value sets the line period in units of 16 system clocks. A 10-bit line count sets the frame length. A 3-bit porch count sets how many blank lines open each frame. Settings are sampled when the block is enabled and again at every frame boundary, so no frame ever mixes two configurations. A sticky error flag reports a line period too short to carry the whole row of beats.

Top module: `lcdTimingGen`

## Requirements
- R1: While reset is high, or from the first clock edge that samples `enable` low, every output is low and both indices are zero; a set error flag is also cleared.
- R2: Speed select 0, 1, 2 and 3 give a shift-clock period of 2, 4, 8 and 8 system clocks. Within each beat the shift clock is low for the first half and high for the second. It toggles only on active lines and only for the first DISP_WIDTH/4 beats of the line. `pixIdx` is the beat number in that window and zero elsewhere.
- R3: A line period lasts 16 × (lineVal + 1) system clocks.
- R4: A frame lasts frameLines line periods, with 0 treated as 1. `lineIdx` counts 0 up to that count minus 1 and then returns to 0.
- R5: `linePulse` is high for exactly the last 8 system clocks of every line period. It is high once per line.
- R6: `framePulse` is high for the whole of line 0 of every frame.
- R7: `lineActive` is high on lines whose index is at least porchLines. A porch count equal to or above the frame length leaves no active line.
- R8: `cfgErr` is set when a sampled setting has 16 × (lineVal + 1) below (DISP_WIDTH/4) × shift-clock period. Once set, it stays high until R1 clears it.
- R9: Settings are sampled only at the edge that starts the block and at the edge that ends each frame. Changes in between have no effect on the frame in progress.
- R10: After the edge that first samples `enable` high, the outputs show line 0, beat 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run control; low stops and clears the block |
| speedSel | input | 2 | Shift-clock period select |
| lineVal | input | 8 | Line period value |
| frameLines | input | 10 | Lines per frame |
| porchLines | input | 3 | Blank lines at the start of each frame |
| shiftClk | output | 1 | Pixel shift clock |
| linePulse | output | 1 | End-of-line pulse |
| framePulse | output | 1 | First-line marker |
| lineActive | output | 1 | Current line carries data |
| lineIdx | output | 10 | Line number within the frame |
| pixIdx | output | $clog2(DISP_WIDTH/4+1) | Beat number within the data window |
| cfgErr | output | 1 | Sticky line-too-short flag |

## Verification
All outputs are combinational decodes of registered counters. Each is due at the first falling edge after the rising edge that moves those counters, and the bench drives and samples only on falling edges. After `enable` rises, sample 0 is taken one edge later and shows line 0, and a frame of F cycles wraps `lineIdx` to 0 at exactly sample F. A disable or a setting change shows its effect one edge later or at the next frame boundary, so every check is placed on a cycle counted from that known start.

// File: rtl/lcdTimingPkg.sv
package lcdTimingPkg;

  localparam int SPD_W   = 2;
  localparam int SCC_W   = 8;
  localparam int FP_W    = 10;
  localparam int PORCH_W = 3;
  localparam int TICK_W  = SCC_W + 4;
  localparam int CMP_W   = TICK_W + 4;
  localparam int SH_W    = 2;
  localparam int LP_LEN  = 8;

  typedef struct packed {
    logic [SPD_W-1:0]   spd;
    logic [SCC_W-1:0]   scc;
    logic [FP_W-1:0]    lines;
    logic [PORCH_W-1:0] porch;
  } lcdCfg_t;

  typedef struct packed {
    logic              clear;
    logic              run;
    logic              active;
    logic [SH_W-1:0]   shift;
    logic [TICK_W-1:0] tickLast;
    logic [CMP_W-1:0]  dataLen;
  } ctrlStrobe_t;

  function automatic logic [SH_W-1:0] speedShift(input logic [SPD_W-1:0] spd);
    case (spd)
      2'd0:    speedShift = 2'd1;
      2'd1:    speedShift = 2'd2;
      default: speedShift = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/lcdTimingCtrl.sv
module lcdTimingCtrl
  import lcdTimingPkg::*;
#(
  parameter int BEATS = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  lcdCfg_t           cfgIn,
  input  logic              lineEnd,
  output ctrlStrobe_t       strobe,
  output logic              framePulse,
  output logic              lineActive,
  output logic [FP_W-1:0]   lineIdx,
  output logic              cfgErr
);

  logic            running;
  lcdCfg_t         cfgQ;
  logic [FP_W-1:0] lineCnt;
  logic            errQ;

  logic [FP_W-1:0]  lineLast;
  logic             frameEnd;
  logic             loadNow;
  logic [CMP_W-1:0] newLineLen;
  logic [CMP_W-1:0] newDataLen;
  logic             newBad;

  always_comb begin
    lineLast   = (cfgQ.lines == '0) ? '0 : cfgQ.lines - 1'b1;
    frameEnd   = lineEnd && (lineCnt == lineLast);
    loadNow    = !running || frameEnd;
    newLineLen = (CMP_W'(cfgIn.scc) + 1'b1) << 4;
    newDataLen = CMP_W'(BEATS) << speedShift(cfgIn.spd);
    newBad     = newLineLen < newDataLen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cfgQ    <= '0;
      lineCnt <= '0;
      errQ    <= 1'b0;
    end else if (!enable) begin
      running <= 1'b0;
      lineCnt <= '0;
      errQ    <= 1'b0;
    end else begin
      running <= 1'b1;
      if (loadNow) begin
        cfgQ    <= cfgIn;
        errQ    <= errQ | newBad;
        lineCnt <= '0;
      end else if (lineEnd) begin
        lineCnt <= lineCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.clear    = rst || !enable;
    strobe.run      = running;
    strobe.active   = running && (lineCnt >= FP_W'(cfgQ.porch));
    strobe.shift    = speedShift(cfgQ.spd);
    strobe.tickLast = {cfgQ.scc, 4'hF};
    strobe.dataLen  = CMP_W'(BEATS) << speedShift(cfgQ.spd);
  end

  assign framePulse = running && (lineCnt == '0);
  assign lineActive = strobe.active;
  assign lineIdx    = lineCnt;
  assign cfgErr     = errQ;

endmodule

// File: rtl/lcdTimingPath.sv
module lcdTimingPath
  import lcdTimingPkg::*;
#(
  parameter int PIX_W = 7
) (
  input  logic             clk,
  input  ctrlStrobe_t      strobe,
  output logic             lineEnd,
  output logic             shiftClk,
  output logic             linePulse,
  output logic [PIX_W-1:0] pixIdx
);

  logic [TICK_W-1:0] tick;
  logic              inWin;
  logic              halfBit;
  logic              beatOn;
  logic [TICK_W-1:0] beatNum;

  always_ff @(posedge clk) begin
    if (strobe.clear || !strobe.run) begin
      tick <= '0;
    end else if (tick == strobe.tickLast) begin
      tick <= '0;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  always_comb begin
    case (strobe.shift)
      2'd1:    halfBit = tick[0];
      2'd2:    halfBit = tick[1];
      default: halfBit = tick[2];
    endcase
    inWin   = CMP_W'(tick) < strobe.dataLen;
    beatOn  = strobe.run && strobe.active && inWin;
    beatNum = tick >> strobe.shift;
  end

  assign shiftClk  = beatOn && halfBit;
  assign pixIdx    = beatOn ? PIX_W'(beatNum) : '0;
  assign linePulse = strobe.run && (tick >= strobe.tickLast - TICK_W'(LP_LEN - 1));
  assign lineEnd   = strobe.run && (tick == strobe.tickLast);

endmodule

// File: rtl/lcdTimingGen.sv
module lcdTimingGen
  import lcdTimingPkg::*;
#(
  parameter  int DISP_WIDTH   = 320,
  parameter  int PIX_PER_BEAT = 4,
  localparam int BEATS        = DISP_WIDTH / PIX_PER_BEAT,
  localparam int PIX_W        = $clog2(BEATS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [1:0]       speedSel,
  input  logic [7:0]       lineVal,
  input  logic [9:0]       frameLines,
  input  logic [2:0]       porchLines,
  output logic             shiftClk,
  output logic             linePulse,
  output logic             framePulse,
  output logic             lineActive,
  output logic [9:0]       lineIdx,
  output logic [PIX_W-1:0] pixIdx,
  output logic             cfgErr
);

  lcdCfg_t     cfgIn;
  ctrlStrobe_t strobe;
  logic        lineEnd;

  always_comb begin
    cfgIn.spd   = speedSel;
    cfgIn.scc   = lineVal;
    cfgIn.lines = frameLines;
    cfgIn.porch = porchLines;
  end

  lcdTimingCtrl #(.BEATS(BEATS)) ctrl (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .cfgIn      (cfgIn),
    .lineEnd    (lineEnd),
    .strobe     (strobe),
    .framePulse (framePulse),
    .lineActive (lineActive),
    .lineIdx    (lineIdx),
    .cfgErr     (cfgErr)
  );

  lcdTimingPath #(.PIX_W(PIX_W)) path (
    .clk       (clk),
    .strobe    (strobe),
    .lineEnd   (lineEnd),
    .shiftClk  (shiftClk),
    .linePulse (linePulse),
    .pixIdx    (pixIdx)
  );

endmodule

// File: rtl/lcdTimingGen_chk.sv
module lcdTimingGen_chk #(
  parameter int BEATS = 80,
  parameter int PIX_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             shiftClk,
  input logic             linePulse,
  input logic             framePulse,
  input logic             lineActive,
  input logic [9:0]       lineIdx,
  input logic [PIX_W-1:0] pixIdx,
  input logic             cfgErr
);

  logic [3:0] lpRun;

  always_ff @(posedge clk) begin
    if (rst) lpRun <= '0;
    else if (linePulse) lpRun <= (lpRun == 4'hF) ? lpRun : lpRun + 1'b1;
    else lpRun <= '0;
  end

  a_r1_idle_low: assert property (@(posedge clk) disable iff (rst)
    $past(!enable) |-> (!shiftClk && !linePulse && !framePulse && !lineActive &&
                        lineIdx == '0 && pixIdx == '0 && !cfgErr));

  a_r5_pulse_width: assert property (@(posedge clk) disable iff (rst)
    ($fell(linePulse) && $past(enable)) |-> (lpRun == 4'd8));

  a_r6_frame_on_line0: assert property (@(posedge clk) disable iff (rst)
    $rose(framePulse) |-> (lineIdx == '0 && !linePulse));

  a_r2_sclk_active_only: assert property (@(posedge clk) disable iff (rst)
    shiftClk |-> lineActive);

  a_r2_pix_bound: assert property (@(posedge clk) disable iff (rst)
    32'(pixIdx) < BEATS);

  a_r4_line_step: assert property (@(posedge clk) disable iff (rst)
    (lineIdx != $past(lineIdx)) |-> (lineIdx == '0 || lineIdx == $past(lineIdx) + 10'd1));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(cfgErr) && $past(enable)) |-> cfgErr);

endmodule

bind lcdTimingGen lcdTimingGen_chk #(.BEATS(BEATS), .PIX_W(PIX_W)) chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .shiftClk   (shiftClk),
  .linePulse  (linePulse),
  .framePulse (framePulse),
  .lineActive (lineActive),
  .lineIdx    (lineIdx),
  .pixIdx     (pixIdx),
  .cfgErr     (cfgErr)
);

// File: tb/lcdTimingGen_test.sv
module lcdTimingGen_test;

  localparam int W    = 32;
  localparam int PIXW = $clog2(W / 4 + 1);
  localparam int NV   = 8;

  // columns: speed, lineVal, frameLines, porch, expErr, frameCycles, sclkRises, pixMax
  localparam int VEC [NV][8] = '{
    '{0, 0, 4, 1, 0,  64, 24, 7},
    '{1, 1, 3, 0, 0,  96, 24, 7},
    '{2, 3, 5, 2, 0, 320, 24, 7},
    '{1, 0, 2, 0, 1,  32,  8, 3},
    '{3, 2, 3, 3, 1, 144,  0, 0},
    '{0, 7, 1, 0, 0, 128,  8, 7},
    '{0, 0, 0, 0, 0,  16,  8, 7},
    '{0, 1, 2, 5, 0,  64,  0, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [1:0] speedSel = '0;
  logic [7:0] lineVal = '0;
  logic [9:0] frameLines = '0;
  logic [2:0] porchLines = '0;
  logic shiftClk, linePulse, framePulse, lineActive, cfgErr;
  logic [9:0] lineIdx;
  logic [PIXW-1:0] pixIdx;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lcdTimingGen #(.DISP_WIDTH(W)) uut (
    .clk(clk), .rst(rst), .enable(enable), .speedSel(speedSel), .lineVal(lineVal),
    .frameLines(frameLines), .porchLines(porchLines), .shiftClk(shiftClk),
    .linePulse(linePulse), .framePulse(framePulse), .lineActive(lineActive),
    .lineIdx(lineIdx), .pixIdx(pixIdx), .cfgErr(cfgErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic allLow(input string req);
    check(!shiftClk && !linePulse && !framePulse && !lineActive && lineIdx == 0 &&
          pixIdx == 0 && !cfgErr, req,
          {shiftClk, linePulse, framePulse, lineActive, cfgErr} + int'(lineIdx) + int'(pixIdx), 0);
  endtask

  task automatic startRun(input int spd, input int scc, input int fl, input int pc);
    @(negedge clk);
    enable = 1'b0;
    speedSel = 2'(spd); lineVal = 8'(scc); frameLines = 10'(fl); porchLines = 3'(pc);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, even with enable high
    enable = 1'b1;
    repeat (3) @(negedge clk);
    allLow("R1 reset");
    rst = 1'b0;
    enable = 1'b0;
    @(negedge clk);
    allLow("R1 idle");

    // Vector table: R2..R8, R10
    for (int v = 0; v < NV; v++) begin
      int n, linePer, fpEff, actLines, frameCyc;
      int lpHigh, lpRises, fpHigh, actCyc, sRises, sHigh, pixMax;
      bit prevLp, prevS;
      n        = (VEC[v][0] == 0) ? 2 : (VEC[v][0] == 1) ? 4 : 8;
      linePer  = 16 * (VEC[v][1] + 1);
      fpEff    = (VEC[v][2] == 0) ? 1 : VEC[v][2];
      actLines = (fpEff > VEC[v][3]) ? fpEff - VEC[v][3] : 0;
      frameCyc = VEC[v][5];
      lpHigh = 0; lpRises = 0; fpHigh = 0; actCyc = 0; sRises = 0; sHigh = 0; pixMax = 0;
      prevLp = 1'b0; prevS = 1'b0;
      startRun(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      for (int s = 0; s <= frameCyc; s++) begin
        if (s == 0) begin
          check(framePulse && lineIdx == 0 && pixIdx == 0, "R10 first sample", int'(lineIdx), 0);
          check(cfgErr == VEC[v][4][0], "R8 error flag", int'(cfgErr), VEC[v][4]);
        end
        if (s == linePer && s < frameCyc)
          check(int'(lineIdx) == 1, "R3 line period", int'(lineIdx), 1);
        if (s == frameCyc - 1)
          check(int'(lineIdx) == fpEff - 1 && linePulse, "R4 last line", int'(lineIdx), fpEff - 1);
        if (s == frameCyc)
          check(lineIdx == 0 && !linePulse, "R4 frame wrap", int'(lineIdx), 0);
        if (s < frameCyc) begin
          if (linePulse) lpHigh++;
          if (linePulse && !prevLp) lpRises++;
          if (framePulse) fpHigh++;
          if (lineActive) actCyc++;
          if (shiftClk) sHigh++;
          if (shiftClk && !prevS) sRises++;
          if (int'(pixIdx) > pixMax) pixMax = int'(pixIdx);
          prevLp = linePulse; prevS = shiftClk;
        end
        @(negedge clk);
      end
      check(lpHigh == 8 * fpEff, "R5 line pulse cycles", lpHigh, 8 * fpEff);
      check(lpRises == fpEff, "R5 line pulse count", lpRises, fpEff);
      check(fpHigh == linePer, "R6 frame pulse cycles", fpHigh, linePer);
      check(actCyc == actLines * linePer, "R7 active cycles", actCyc, actLines * linePer);
      check(sRises == VEC[v][6], "R2 shift clock beats", sRises, VEC[v][6]);
      check(sHigh == sRises * n / 2, "R2 shift clock high time", sHigh, sRises * n / 2);
      check(pixMax == VEC[v][7], "R2 beat index max", pixMax, VEC[v][7]);
    end

    // R1: disable mid-run clears everything one edge later
    startRun(0, 0, 4, 1);
    repeat (20) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    allLow("R1 disable");

    // R9: setting change mid-frame waits for the frame boundary
    begin
      int cnt;
      int prevLine;
      startRun(0, 0, 4, 1);
      cnt = 0;
      prevLine = 0;
      for (int s = 0; s < 400; s++) begin
        if (s == 5) lineVal = 8'd1;
        if (s > 0 && lineIdx == 0 && prevLine == 3) break;
        prevLine = int'(lineIdx);
        cnt++;
        @(negedge clk);
      end
      check(cnt == 64, "R9 old frame kept", cnt, 64);
      cnt = 0;
      for (int s = 0; s < 400; s++) begin
        if (lineIdx == 1) break;
        cnt++;
        @(negedge clk);
      end
      check(cnt == 32, "R9 new line period", cnt, 32);
    end

    // R8: sticky error survives a good frame, cleared by disable
    startRun(1, 0, 2, 0);
    repeat (5) @(negedge clk);
    lineVal = 8'd3; speedSel = 2'd0;
    repeat (150) @(negedge clk);
    check(cfgErr, "R8 sticky", int'(cfgErr), 1);
    check(lineIdx == 1 || lineIdx == 0, "R8 good frame running", int'(lineIdx), 0);
    enable = 1'b0;
    @(negedge clk);
    check(!cfgErr, "R8 cleared by disable", int'(cfgErr), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule